// File: doc/BRIEF.md
# Channel-Windowed PRBS Transmitter

This block generates a pseudo-random test pattern and places it into a selected window of channels on one time-division serial output stream. The frame timing logic supplies the current stream index and channel index, together with a one-cycle strobe for each bit time. When transmission is enabled and the position falls inside the configured window, the block raises an override flag and presents the next pattern bit. The serial output multiplexer then sends that bit in place of the normally switched data.

The window is set by three values: a stream number, a start channel, and a count of extra consecutive channels after the start. The window never wraps past the last channel of the frame. Two pattern lengths are available, 2^15-1 and 2^23-1, chosen by one select input. The shift register advances only on bits that fall inside the window. As a result, the sequence runs on without gaps from one frame to the next. The receive-side checker is a separate block with its own enable, so one-way testing and loopback testing both work.

Top module: `prbs_window_tx`

## Requirements
- R1: One clock after a cycle with `bit_stb` high, `ovr_valid` is high if and only if `tx_en` is high, `cur_stream` equals `cfg_stream`, and `cfg_start <= cur_chan <= cfg_start + cfg_len`.
- R2: The window does not wrap. When `cfg_start + cfg_len` is past the last channel, channels below `cfg_start` (including channel 0) are never overridden.
- R3: With `long_sel` = 0, the pattern comes from a 15-bit register. Each window bit shifts it one place toward the MSB, and the new LSB is bit 14 XOR bit 13 (x^15+x^14+1). The output bit is the inverse of bit 14, taken before the shift.
- R4: With `long_sel` = 1, the pattern comes from a 23-bit register. Each window bit shifts it one place toward the MSB, and the new LSB is bit 22 XOR bit 17 (x^23+x^18+1). The output bit is the inverse of bit 22, taken before the shift.
- R5: The register advances exactly once per window bit and holds on every other cycle. The sequence therefore continues across channels outside the window and across frame boundaries.
- R6: The register is reloaded with the all-ones seed in any clock cycle where `tx_en` is low or `long_sel` differs from its value in the previous cycle. In such a cycle, a strobe produces no override. The first window bit after a reload is 0.
- R7: `prbs_bit` is 0 whenever `ovr_valid` is 0. Both outputs are registered and are low in the cycle after any cycle without a strobe.
- R8: While `rst` is high and in the first cycle after it, both outputs are 0. Reset loads the all-ones seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| long_sel | input | 1 | 0: 2^15-1 pattern, 1: 2^23-1 pattern |
| cfg_stream | input | $clog2(STREAMS) | Target stream number |
| cfg_start | input | $clog2(CHANNELS) | First channel of the window |
| cfg_len | input | $clog2(CHANNELS) | Extra consecutive channels after the start |
| cur_stream | input | $clog2(STREAMS) | Stream index of the current bit |
| cur_chan | input | $clog2(CHANNELS) | Channel index of the current bit |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| prbs_bit | output | 1 | Pattern bit to send |
| ovr_valid | output | 1 | Replace the switched data with `prbs_bit` |

## Verification
The assertions assume that `cur_stream` and `cur_chan` stay below their parameter limits. They also assume that the configuration inputs and `long_sel` are stable in any cycle that carries a strobe. The bench meets these assumptions by changing configuration only on idle cycles, each followed by a strobe-free cycle. It sweeps every stream, channel and bit position of a small frame, alternating each strobe with an idle cycle. It checks every output against a bench-side shift-register model that restarts from all ones whenever the bench disables transmission or switches the pattern length.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  // Shift-register variants: register width and second feedback tap (1-based)
  typedef struct packed {
    int unsigned width;
    int unsigned tap;
  } lfsr_cfg_t;

  localparam int unsigned NUM_VARIANTS = 2;
  localparam int unsigned MAX_WIDTH    = 23;

  // index 0 = short pattern, index 1 = long pattern
  localparam lfsr_cfg_t VARIANTS [NUM_VARIANTS] = '{
    '{width: 15, tap: 14},
    '{width: 23, tap: 18}
  };
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
  import prbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic advance,
  input  logic long_sel,
  output logic pat_bit
);
  logic [MAX_WIDTH-1:0] state;
  logic [MAX_WIDTH-1:0] nxt   [NUM_VARIANTS];
  logic                 outb  [NUM_VARIANTS];

  for (genvar g = 0; g < NUM_VARIANTS; g++) begin : g_var
    localparam int unsigned W = VARIANTS[g].width;
    localparam int unsigned T = VARIANTS[g].tap;
    logic fb;
    assign fb      = state[W-1] ^ state[T-1];
    assign outb[g] = ~state[W-1];
    always_comb begin
      nxt[g]        = state;
      nxt[g][W-1:0] = {state[W-2:0], fb};
    end
  end

  assign pat_bit = long_sel ? outb[1] : outb[0];

  always_ff @(posedge clk) begin
    if (rst || reload) state <= '1;
    else if (advance)  state <= long_sel ? nxt[1] : nxt[0];
  end
endmodule

// File: rtl/prbs_window_match.sv
module prbs_window_match #(
  parameter int SW = 3,
  parameter int CW = 5
) (
  input  logic [SW-1:0] cfg_stream,
  input  logic [CW-1:0] cfg_start,
  input  logic [CW-1:0] cfg_len,
  input  logic [SW-1:0] cur_stream,
  input  logic [CW-1:0] cur_chan,
  output logic          hit
);
  logic [CW:0] last_ch;
  assign last_ch = {1'b0, cfg_start} + {1'b0, cfg_len};
  // channel indices never exceed the frame, so an end past it clamps naturally
  assign hit = (cur_stream == cfg_stream) && (cur_chan >= cfg_start) &&
               ({1'b0, cur_chan} <= last_ch);
endmodule

// File: rtl/prbs_window_tx.sv
module prbs_window_tx #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CHANNELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          long_sel,
  input  logic [SW-1:0] cfg_stream,
  input  logic [CW-1:0] cfg_start,
  input  logic [CW-1:0] cfg_len,
  input  logic [SW-1:0] cur_stream,
  input  logic [CW-1:0] cur_chan,
  input  logic          bit_stb,
  output logic          prbs_bit,
  output logic          ovr_valid
);
  logic mode_q, mode_chg, hit, adv, reload, pat_bit;

  assign mode_chg = long_sel != mode_q;
  assign reload   = !tx_en || mode_chg;
  assign adv      = bit_stb && hit && !reload;

  prbs_window_match #(.SW(SW), .CW(CW)) u_match (
    .cfg_stream(cfg_stream), .cfg_start(cfg_start), .cfg_len(cfg_len),
    .cur_stream(cur_stream), .cur_chan(cur_chan), .hit(hit)
  );

  prbs_lfsr u_lfsr (
    .clk(clk), .rst(rst), .reload(reload), .advance(adv),
    .long_sel(long_sel), .pat_bit(pat_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      ovr_valid <= 1'b0;
      prbs_bit  <= 1'b0;
    end else begin
      mode_q    <= long_sel;
      ovr_valid <= adv;
      prbs_bit  <= adv && pat_bit;
    end
  end
endmodule

// File: rtl/prbs_window_tx_chk.sv
module prbs_window_tx_chk #(
  parameter int SW = 3,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_en,
  input logic          long_sel,
  input logic [SW-1:0] cfg_stream,
  input logic [CW-1:0] cfg_start,
  input logic [CW-1:0] cfg_len,
  input logic [SW-1:0] cur_stream,
  input logic [CW-1:0] cur_chan,
  input logic          bit_stb,
  input logic          prbs_bit,
  input logic          ovr_valid
);
  logic [CW:0] last_ch;
  assign last_ch = {1'b0, cfg_start} + {1'b0, cfg_len};

  // R1
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(bit_stb && tx_en) |=> !ovr_valid);
  // R1
  stream_match_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && cur_stream != cfg_stream) |=> !ovr_valid);
  // R2
  below_start_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && cur_chan < cfg_start) |=> !ovr_valid);
  // R1
  past_end_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && {1'b0, cur_chan} > last_ch) |=> !ovr_valid);
  // R6
  mode_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (long_sel != $past(long_sel)) |=> !ovr_valid);
  // R7
  quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
    !ovr_valid |-> !prbs_bit);
  // R8
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ovr_valid && !prbs_bit));
endmodule

bind prbs_window_tx prbs_window_tx_chk #(.SW(SW), .CW(CW)) u_chk (.*);

// File: tb/sim_prbs_window_tx.sv
module sim_prbs_window_tx;
  localparam int ST = 4, CH = 16, SW = 2, CW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_en = 1'b0, long_sel = 1'b0, bit_stb = 1'b0;
  logic [SW-1:0] cfg_stream = '0, cur_stream = '0;
  logic [CW-1:0] cfg_start = '0, cfg_len = '0, cur_chan = '0;
  logic prbs_bit, ovr_valid;
  int checks = 0, fails = 0;
  logic [22:0] m = '1;

  always #5 clk = ~clk;

  prbs_window_tx #(.STREAMS(ST), .CHANNELS(CH)) u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (s%0d c%0d)", tag, act, exp, cur_stream, cur_chan);
    end
  endtask

  task automatic set_cfg(input logic en, input logic ls, input int s, input int st, input int ln);
    @(negedge clk);
    if (!en || ls != long_sel) m = '1;
    tx_en = en; long_sel = ls;
    cfg_stream = SW'(s); cfg_start = CW'(st); cfg_len = CW'(ln);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input int s, input int c, input string vtag);
    logic hit, eb;
    int w;
    @(negedge clk);
    cur_stream = SW'(s); cur_chan = CW'(c); bit_stb = 1'b1;
    hit = tx_en && (s == int'(cfg_stream)) && (c >= int'(cfg_start)) &&
          (c <= int'(cfg_start) + int'(cfg_len));
    w = long_sel ? 23 : 15;
    eb = hit ? ~m[w-1] : 1'b0;
    if (hit) begin
      if (long_sel) m = {m[21:0], m[22] ^ m[17]};
      else          m[14:0] = {m[13:0], m[14] ^ m[13]};
    end
    @(negedge clk);
    bit_stb = 1'b0;
    chk(vtag, ovr_valid, hit);
    chk(long_sel ? "R4" : "R3", prbs_bit, eb);
    @(negedge clk);
    chk("R7", ovr_valid | prbs_bit, 1'b0);
  endtask

  task automatic frame(input string vtag);
    for (int c = 0; c < CH; c++)
      for (int b = 0; b < 8; b++)
        for (int s = 0; s < ST; s++) strobe(s, c, vtag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", ovr_valid, 1'b0);
    chk("R8", prbs_bit, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", ovr_valid | prbs_bit, 1'b0);
    // short pattern, mid-frame window, two frames for continuity
    set_cfg(1'b1, 1'b0, 3, 5, 4);
    frame("R1");
    frame("R5");
    // long pattern with window end past the last channel
    set_cfg(1'b1, 1'b1, 0, 12, 10);
    frame("R2");
    frame("R5");
    // single-channel window
    set_cfg(1'b1, 1'b1, 2, 0, 0);
    frame("R1");
    // disabled: nothing overridden, then restart from seed
    set_cfg(1'b0, 1'b1, 2, 0, 15);
    frame("R6");
    set_cfg(1'b1, 1'b1, 1, 0, 15);
    for (int i = 0; i < 64; i++) strobe(1, i / 8, "R6");
    // switch length mid-sequence: reload
    set_cfg(1'b1, 1'b0, 1, 0, 15);
    frame("R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule